// File: doc/BRIEF.md
# Coprocessor Instruction Handshake Sequencer

This block sits on the main-core side of the link to an attached coprocessor. When an internal operation, a register move to or from the coprocessor, or a multi-word coprocessor load or store is issued, the sequencer presents a phase code to the coprocessor and samples its two-bit answer every cycle. It spends idle cycles while the coprocessor reports busy, and it can abandon the wait when an interrupt is pending. For loads and stores it drives a word-wide memory port and steps the address by one word each time the coprocessor asks for another word.

The instruction ends with a one-cycle `done` pulse. A status code comes with the pulse and tells the core whether to carry on, raise an undefined-instruction exception, raise a data abort, or take the interrupt. The same pulse qualifies the base-register writeback permission and the source of the interrupt that was taken. The coprocessor number is decoded outside this block, and so is the permission table. Only the permission result reaches the sequencer.

Top module: `cp_handshake_seq`

## Requirements
- R1: A start with `access_ok` low sends no phase to the coprocessor. It produces `done` with status UNDEF (1) in the cycle after the start.
- R2: The sequence opens with phase FIRST (1). Each BUSY (1) response is followed by one internal cycle (`cyc_kind` = 1) and then a BUSY phase (2). After b busy answers an internal operation completes with `done` 2+2b cycles after the start.
- R3: If an interrupt is pending at the end of an idle cycle, the sequencer presents exactly one INTERRUPT phase (3). It then ends with status INTR (3) and `wb_en` low.
- R4: An interrupt is pending when `rst_pend_n` is low, or `fiq_n` is low with `fiq_mask` clear, or `irq_n` is low with `irq_mask` clear. The first true term of that list wins. `intr_cause` reports it as 1, 2 or 3, and as 0 when the end is not an interrupt.
- R5: A CANT (2) response to FIRST or BUSY ends the instruction with status UNDEF.
- R6: A load (op 3) issues a TRANSFER phase (4). Each following cycle it reads the current address and passes the word on `cp_wdata` with a DATA phase (5). While the answer is INC (3) the address grows by 4 bytes.
- R7: A store (op 4) presents a DATA phase and writes `cp_rdata` to memory in the same cycle. While the answer is INC the address grows by 4 bytes.
- R8: `mem_abort` on any word ends the transfer with status ABORT (2), even when the coprocessor answered INC in that cycle. An aborted load word is not passed on with a DATA phase.
- R9: `wb_en` at `done` equals `wb_req` for a load or store that ends OK. After an abort it equals `wb_req` AND `late_abort`. In every other case it is 0.
- R10: A successful register read (op 2) takes one coprocessor cycle (`cyc_kind` = 2) followed by one internal cycle, and returns the word answered with the final ready response on `rd_data`. A register write (op 1) takes one coprocessor cycle and drives `src_data` on `cp_wdata`.
- R11: `done` is low after reset and lasts exactly one cycle. Status codes: OK 0, UNDEF 1, ABORT 2, INTR 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction (accepted when idle) |
| op | input | 3 | 0 internal, 1 write to coprocessor, 2 read from coprocessor, 3 load, 4 store |
| access_ok | input | 1 | Coprocessor access permitted |
| wb_req | input | 1 | Instruction requests base writeback |
| late_abort | input | 1 | Late-abort option selected |
| start_addr | input | AW | First word address of a transfer |
| src_data | input | DW | Core register value for a register write |
| cp_phase | output | 3 | Phase: 0 none, 1 FIRST, 2 BUSY, 3 INTERRUPT, 4 TRANSFER, 5 DATA |
| cp_resp | input | 2 | Answer: 0 READY, 1 BUSY, 2 CANT, 3 INC |
| cp_wdata | output | DW | Word handed to the coprocessor |
| cp_rdata | input | DW | Word offered by the coprocessor |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, same cycle |
| mem_abort | input | 1 | Memory access aborted, same cycle |
| rst_pend_n | input | 1 | Core reset request, active low |
| fiq_n | input | 1 | Fast interrupt, active low |
| irq_n | input | 1 | Normal interrupt, active low |
| fiq_mask | input | 1 | Fast interrupt disabled |
| irq_mask | input | 1 | Normal interrupt disabled |
| done | output | 1 | One-cycle end-of-instruction pulse |
| status | output | 2 | End status, valid with done |
| wb_en | output | 1 | Base writeback allowed, valid with done |
| rd_data | output | DW | Result of a register read |
| cyc_kind | output | 2 | 0 none, 1 internal, 2 coprocessor, 3 memory |
| intr_cause | output | 2 | Source of a taken interrupt, valid with done |

## Verification
Two decisions can land in the same cycle. A memory abort can come in the very cycle in which the coprocessor answers INC and asks for another word. The bench sets up multi-word loads and stores whose second address aborts while increments are still outstanding. The run must stop there with ABORT status, a single passed-on load word and no further memory access, and `wb_en` must follow the late-abort input. A second overlap is a busy answer while an interrupt line is already asserted. The bench checks that the interrupt is taken only after the idle cycle and only when its mask is clear.

// File: rtl/cphs_pkg.sv
// Package: shared encodings of the coprocessor handshake sequencer.
// Assumes: all codes fit the port widths of cp_handshake_seq.
package cphs_pkg;

    typedef enum logic [2:0] {
        PH_NONE  = 3'd0,
        PH_FIRST = 3'd1,
        PH_BUSY  = 3'd2,
        PH_INTR  = 3'd3,
        PH_XFER  = 3'd4,
        PH_DATA  = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        RS_READY = 2'd0,
        RS_BUSY  = 2'd1,
        RS_CANT  = 2'd2,
        RS_INC   = 2'd3
    } resp_e;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_UNDEF = 2'd1,
        ST_ABORT = 2'd2,
        ST_INTR  = 2'd3
    } status_e;

    typedef enum logic [2:0] {
        OP_INTERNAL = 3'd0,
        OP_TO_CP    = 3'd1,
        OP_FROM_CP  = 3'd2,
        OP_LOAD     = 3'd3,
        OP_STORE    = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        CY_NONE = 2'd0,
        CY_INT  = 2'd1,
        CY_COP  = 2'd2,
        CY_MEM  = 2'd3
    } cyc_e;

    typedef enum logic [3:0] {
        S_IDLE, S_FIRST, S_WAIT, S_BUSY, S_INTR, S_XFER,
        S_LD, S_ST, S_CC, S_CI, S_DONE
    } state_e;

endpackage

// File: rtl/cphs_irq_detect.sv
// Module: interrupt-pending detector with fixed priority.
// Does: flags a pending exception and encodes the winning source
//       (1 reset request, 2 fast interrupt, 3 normal interrupt).
// Assumes: all request lines are active low and already synchronous.
module cphs_irq_detect #(
    parameter int NSRC = 3
) (
    input  logic            rst_pend_n,
    input  logic            fiq_n,
    input  logic            irq_n,
    input  logic            fiq_mask,
    input  logic            irq_mask,
    output logic            pend,
    output logic [1:0]      cause
);
    localparam int CW = $clog2(NSRC + 1);

    logic [NSRC-1:0] req;

    // Qualify each request line with its mask.
    always_comb begin
        req    = '0;
        req[0] = ~rst_pend_n;
        req[1] = ~fiq_n & ~fiq_mask;
        req[2] = ~irq_n & ~irq_mask;
    end

    logic [CW-1:0] win;

    // Lowest index wins: scan from the highest index down.
    always_comb begin
        win = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) win = CW'(i + 1);
        end
    end

    assign pend  = |req;
    assign cause = 2'(win);

    // A cause is reported exactly when something is pending (R4).
    always_comb begin
        assert_cause_matches_pend_R4: assert (pend == (cause != 2'd0));
    end

endmodule

// File: rtl/cphs_addr_step.sv
// Module: transfer address register.
// Does: loads the start address when an instruction is accepted and
//       advances by one word on each increment request.
// Assumes: load and step are never requested in the same cycle.
module cphs_addr_step #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] start_addr,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] INCR = AW'(STEP);

    // Address register: reset, load or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr <= '0;
        else if (load)   addr <= start_addr;
        else if (step)   addr <= addr + INCR;
    end

    // Each step advances the address by exactly one word (R6, R7).
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (addr == $past(addr) + INCR));

endmodule

// File: rtl/cphs_ctrl.sv
// Module: handshake control state machine.
// Does: sequences phases, idle cycles, memory words and the end pulse,
//       and decides status and writeback permission.
// Assumes: memory and coprocessor answer in the cycle they are addressed.
module cphs_ctrl
    import cphs_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  op_e           op,
    input  logic          access_ok,
    input  logic          wb_req,
    input  logic          late_abort,
    input  resp_e         resp,
    input  logic [DW-1:0] cp_rdata,
    input  logic          irq_pend,
    input  logic [1:0]    irq_cause,
    input  logic          mem_abort,
    output phase_e        phase,
    output logic          mem_req,
    output logic          mem_we,
    output logic          pass_mem,
    output logic          addr_load,
    output logic          addr_step,
    output logic          done,
    output status_e       status,
    output logic          wb_en,
    output logic [DW-1:0] rd_data,
    output cyc_e          cyc_kind,
    output logic [1:0]    intr_cause
);
    state_e  state, nxt;
    op_e     op_q;
    logic    wb_q, late_q, wbfin_q;
    status_e stat_q;
    logic    fin, fin_wb;
    status_e fin_st;
    logic    grant;

    // A ready or increment answer to FIRST/BUSY lets the instruction go on.
    assign grant = (resp == RS_READY) || (resp == RS_INC);

    // Next-state and end-of-instruction decision.
    always_comb begin
        nxt    = state;
        fin    = 1'b0;
        fin_st = ST_OK;
        fin_wb = 1'b0;
        case (state)
            S_IDLE: if (start) begin
                if (!access_ok) begin
                    nxt = S_DONE; fin = 1'b1; fin_st = ST_UNDEF;
                end else begin
                    nxt = S_FIRST;
                end
            end
            S_FIRST, S_BUSY: begin
                if (resp == RS_BUSY) begin
                    nxt = S_WAIT;
                end else if (resp == RS_CANT) begin
                    nxt = S_DONE; fin = 1'b1; fin_st = ST_UNDEF;
                end else begin
                    case (op_q)
                        OP_TO_CP, OP_FROM_CP: nxt = S_CC;
                        OP_LOAD:              nxt = S_XFER;
                        OP_STORE:             nxt = S_ST;
                        default: begin
                            nxt = S_DONE; fin = 1'b1; fin_st = ST_OK;
                        end
                    endcase
                end
            end
            S_WAIT:  nxt = irq_pend ? S_INTR : S_BUSY;
            S_INTR: begin
                nxt = S_DONE; fin = 1'b1; fin_st = ST_INTR;
            end
            S_XFER:  nxt = S_LD;
            S_LD, S_ST: begin
                if (mem_abort) begin
                    nxt = S_DONE; fin = 1'b1; fin_st = ST_ABORT;
                    fin_wb = wb_q & late_q;
                end else if (resp != RS_INC) begin
                    nxt = S_DONE; fin = 1'b1; fin_st = ST_OK;
                    fin_wb = wb_q;
                end
            end
            S_CC: begin
                if (op_q == OP_FROM_CP) begin
                    nxt = S_CI;
                end else begin
                    nxt = S_DONE; fin = 1'b1; fin_st = ST_OK;
                end
            end
            S_CI: begin
                nxt = S_DONE; fin = 1'b1; fin_st = ST_OK;
            end
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Capture the instruction attributes when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_INTERNAL;
            wb_q   <= 1'b0;
            late_q <= 1'b0;
        end else if (state == S_IDLE && start) begin
            op_q   <= op;
            wb_q   <= wb_req;
            late_q <= late_abort;
        end
    end

    // Latch end status and writeback permission for the done cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q  <= ST_OK;
            wbfin_q <= 1'b0;
        end else if (fin) begin
            stat_q  <= fin_st;
            wbfin_q <= fin_wb;
        end
    end

    // Record the source of an interrupt that abandons the wait.
    always_ff @(posedge clk) begin
        if (!rst_n)                                intr_cause <= 2'd0;
        else if (state == S_IDLE && start)         intr_cause <= 2'd0;
        else if (state == S_WAIT && irq_pend)      intr_cause <= irq_cause;
    end

    // Hold the word the coprocessor offers with its final grant on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if ((state == S_FIRST || state == S_BUSY) && grant
                     && op_q == OP_FROM_CP) begin
            rd_data <= cp_rdata;
        end
    end

    // Phase presented to the coprocessor.
    always_comb begin
        case (state)
            S_FIRST: phase = PH_FIRST;
            S_BUSY:  phase = PH_BUSY;
            S_INTR:  phase = PH_INTR;
            S_XFER:  phase = PH_XFER;
            S_LD:    phase = mem_abort ? PH_NONE : PH_DATA;
            S_ST:    phase = PH_DATA;
            default: phase = PH_NONE;
        endcase
    end

    // Cycle classification.
    always_comb begin
        case (state)
            S_WAIT, S_CI: cyc_kind = CY_INT;
            S_CC:         cyc_kind = CY_COP;
            S_LD, S_ST:   cyc_kind = CY_MEM;
            default:      cyc_kind = CY_NONE;
        endcase
    end

    assign mem_req   = (state == S_LD) || (state == S_ST);
    assign mem_we    = (state == S_ST);
    assign pass_mem  = (state == S_LD);
    assign addr_load = (state == S_IDLE) && start;
    assign addr_step = mem_req && !mem_abort && (resp == RS_INC);
    assign done      = (state == S_DONE);
    assign status    = stat_q;
    assign wb_en     = done && wbfin_q;

    // Denied access ends one cycle later as undefined (R1).
    assert_denied_undef_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && !access_ok) |=> (done && status == ST_UNDEF));

    // A busy answer is followed by an internal cycle (R2).
    assert_busy_idles_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_FIRST || phase == PH_BUSY) && resp == RS_BUSY) |=> (cyc_kind == CY_INT));

    // An interrupt phase is followed straight away by the interrupted end (R3).
    assert_intr_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INTR) |=> (done && status == ST_INTR && !wb_en));

    // A cannot answer ends as undefined (R5).
    assert_cant_undef_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_FIRST || phase == PH_BUSY) && resp == RS_CANT) |=> (done && status == ST_UNDEF));

    // A memory abort ends the transfer at once, whatever the answer (R8).
    assert_abort_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_abort) |=> (done && status == ST_ABORT && !mem_req));

    // Writeback is never granted outside memory transfers (R9).
    assert_wb_only_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (status == ST_UNDEF || status == ST_INTR)) |-> !wb_en);

    // A register read spends a coprocessor cycle and then an internal one (R10).
    assert_read_cycles_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == CY_COP && op_q == OP_FROM_CP) |=> (cyc_kind == CY_INT));

    // The end pulse lasts one cycle (R11).
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/cp_handshake_seq.sv
// Module: coprocessor instruction handshake sequencer (top).
// Does: joins the control machine, the interrupt detector and the
//       transfer address register, and routes the data words.
// Assumes: start is only honoured when the sequencer is idle.
module cp_handshake_seq
    import cphs_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic          access_ok,
    input  logic          wb_req,
    input  logic          late_abort,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] src_data,
    output logic [2:0]    cp_phase,
    input  logic [1:0]    cp_resp,
    output logic [DW-1:0] cp_wdata,
    input  logic [DW-1:0] cp_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_abort,
    input  logic          rst_pend_n,
    input  logic          fiq_n,
    input  logic          irq_n,
    input  logic          fiq_mask,
    input  logic          irq_mask,
    output logic          done,
    output logic [1:0]    status,
    output logic          wb_en,
    output logic [DW-1:0] rd_data,
    output logic [1:0]    cyc_kind,
    output logic [1:0]    intr_cause
);
    phase_e     phase;
    status_e    stat;
    cyc_e       cyc;
    logic       irq_pend;
    logic [1:0] irq_cause;
    logic       pass_mem, addr_load, addr_step;

    cphs_irq_detect #(.NSRC(3)) i_irq (
        .rst_pend_n (rst_pend_n),
        .fiq_n      (fiq_n),
        .irq_n      (irq_n),
        .fiq_mask   (fiq_mask),
        .irq_mask   (irq_mask),
        .pend       (irq_pend),
        .cause      (irq_cause)
    );

    cphs_addr_step #(.AW(AW), .STEP(WORD_BYTES)) i_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (addr_load),
        .step       (addr_step),
        .start_addr (start_addr),
        .addr       (mem_addr)
    );

    cphs_ctrl #(.DW(DW)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op         (op_e'(op)),
        .access_ok  (access_ok),
        .wb_req     (wb_req),
        .late_abort (late_abort),
        .resp       (resp_e'(cp_resp)),
        .cp_rdata   (cp_rdata),
        .irq_pend   (irq_pend),
        .irq_cause  (irq_cause),
        .mem_abort  (mem_abort),
        .phase      (phase),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .pass_mem   (pass_mem),
        .addr_load  (addr_load),
        .addr_step  (addr_step),
        .done       (done),
        .status     (stat),
        .wb_en      (wb_en),
        .rd_data    (rd_data),
        .cyc_kind   (cyc),
        .intr_cause (intr_cause)
    );

    // Word routing: loads pass memory data on, otherwise the core register.
    assign cp_wdata  = pass_mem ? mem_rdata : src_data;
    assign mem_wdata = cp_rdata;
    assign cp_phase  = phase;
    assign status    = stat;
    assign cyc_kind  = cyc;

endmodule

// File: tb/test_cp_handshake_seq.sv
`timescale 1ns/1ps
module test_cp_handshake_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        access_ok = 1'b1, wb_req = 1'b0, late_abort = 1'b0;
    logic [31:0] start_addr = '0, src_data = '0;
    logic [2:0]  cp_phase;
    logic [1:0]  cp_resp;
    logic [31:0] cp_wdata, cp_rdata, mem_addr, mem_wdata, mem_rdata, rd_data;
    logic        mem_req, mem_we, mem_abort, done, wb_en;
    logic        rst_pend_n = 1'b1, fiq_n = 1'b1, irq_n = 1'b1, fiq_mask = 1'b0, irq_mask = 1'b0;
    logic [1:0]  status, cyc_kind, intr_cause;

    int tests = 0, fails = 0;
    int busy_left = 0, inc_left = 0;
    bit cant_mode = 0, abort_en = 0;
    logic [31:0] abort_addr = '0, rdbase = 32'hC500_0000;
    int n_first, n_busyph, n_intr, n_xfer, n_data, n_icyc, n_ccyc, n_memrd, n_memwr;
    logic [31:0] dlog [16];
    logic [31:0] wa [16];
    logic [31:0] wd [16];
    logic [31:0] first_wdata;
    int lat;
    logic [1:0] r_status, r_cause;
    logic r_wb;
    logic [31:0] r_rd;

    always #2.5 clk = ~clk;

    cp_handshake_seq i_cp_handshake_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .access_ok(access_ok),
        .wb_req(wb_req), .late_abort(late_abort), .start_addr(start_addr),
        .src_data(src_data), .cp_phase(cp_phase), .cp_resp(cp_resp),
        .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_abort(mem_abort), .rst_pend_n(rst_pend_n), .fiq_n(fiq_n), .irq_n(irq_n),
        .fiq_mask(fiq_mask), .irq_mask(irq_mask), .done(done), .status(status),
        .wb_en(wb_en), .rd_data(rd_data), .cyc_kind(cyc_kind), .intr_cause(intr_cause)
    );

    // Memory model: answers in the same cycle.
    assign mem_rdata = {16'hA5A5, mem_addr[15:0]};
    assign mem_abort = abort_en && mem_req && (mem_addr == abort_addr);
    assign cp_rdata  = rdbase | 32'(n_data);

    // Coprocessor model.
    always_comb begin
        case (cp_phase)
            3'd1, 3'd2: cp_resp = (busy_left != 0) ? 2'd1 : (cant_mode ? 2'd2 : 2'd0);
            3'd5:       cp_resp = (inc_left != 0) ? 2'd3 : 2'd0;
            default:    cp_resp = 2'd0;
        endcase
    end

    // Monitor: count phases and cycles, log words.
    always @(posedge clk) begin
        if (cp_phase == 3'd1) begin n_first++; first_wdata = cp_wdata; end
        if (cp_phase == 3'd2) n_busyph++;
        if (cp_phase == 3'd3) n_intr++;
        if (cp_phase == 3'd4) n_xfer++;
        if ((cp_phase == 3'd1 || cp_phase == 3'd2) && busy_left != 0) busy_left--;
        if (cyc_kind == 2'd1) n_icyc++;
        if (cyc_kind == 2'd2) n_ccyc++;
        if (mem_req && !mem_we) n_memrd++;
        if (mem_req && mem_we) begin
            if (n_memwr < 16) begin wa[n_memwr] = mem_addr; wd[n_memwr] = mem_wdata; end
            n_memwr++;
        end
        if (cp_phase == 3'd5) begin
            if (n_data < 16) dlog[n_data] = cp_wdata;
            n_data++;
            if (inc_left != 0) inc_left--;
        end
    end

    task automatic summary_and_end();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary_and_end();
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input int opv, input bit acc, input logic [31:0] a, input bit wb, input bit late);
        n_first = 0; n_busyph = 0; n_intr = 0; n_xfer = 0; n_data = 0;
        n_icyc = 0; n_ccyc = 0; n_memrd = 0; n_memwr = 0;
        op = 3'(opv); access_ok = acc; start_addr = a; wb_req = wb; late_abort = late;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        r_status = status; r_wb = wb_en; r_rd = rd_data; r_cause = intr_cause;
        @(negedge clk);
        chk(!done, "R11 done one cycle", 32'(done), 0);
    endtask

    task automatic t_reset();
        chk(done == 1'b0, "R11 reset done", 32'(done), 0);
        chk(cp_phase == 3'd0 && !mem_req, "R11 reset idle", 32'(cp_phase), 0);
    endtask

    task automatic t_denied();
        busy_left = 0; cant_mode = 0;
        run(3, 0, 32'h80, 1, 1);
        chk(lat == 1, "R1 denied latency", 32'(lat), 1);
        chk(r_status == 2'd1, "R1 denied status", 32'(r_status), 1);
        chk(n_first == 0 && n_memrd == 0, "R1 no handshake", 32'(n_first), 0);
        chk(r_wb == 0, "R9 no wb on denied", 32'(r_wb), 0);
    endtask

    task automatic t_busy();
        busy_left = 3; cant_mode = 0;
        run(0, 1, 0, 0, 0);
        chk(lat == 8, "R2 busy latency", 32'(lat), 8);
        chk(n_first == 1 && n_busyph == 3, "R2 busy phases", 32'(n_busyph), 3);
        chk(n_icyc == 3, "R2 idle cycles", 32'(n_icyc), 3);
        chk(r_status == 2'd0, "R2 status ok", 32'(r_status), 0);
    endtask

    task automatic t_cant();
        busy_left = 1; cant_mode = 1;
        run(2, 1, 0, 1, 0);
        chk(lat == 4, "R5 cant latency", 32'(lat), 4);
        chk(r_status == 2'd1, "R5 cant status", 32'(r_status), 1);
        chk(n_ccyc == 0, "R5 no transfer", 32'(n_ccyc), 0);
        cant_mode = 0;
    endtask

    task automatic t_intr();
        busy_left = 5; irq_n = 0; irq_mask = 0;
        run(3, 1, 32'h40, 1, 1);
        chk(lat == 4, "R3 intr latency", 32'(lat), 4);
        chk(n_intr == 1 && n_busyph == 0, "R3 one intr phase", 32'(n_intr), 1);
        chk(r_status == 2'd3, "R3 intr status", 32'(r_status), 3);
        chk(r_wb == 0 && n_memrd == 0, "R3 no wb no mem", 32'(r_wb), 0);
        chk(r_cause == 2'd3, "R4 normal cause", 32'(r_cause), 3);
        irq_n = 1;
    endtask

    task automatic t_prio();
        busy_left = 2; fiq_n = 0; irq_n = 0;
        run(0, 1, 0, 0, 0);
        chk(r_cause == 2'd2, "R4 fast beats normal", 32'(r_cause), 2);
        busy_left = 2; rst_pend_n = 0;
        run(0, 1, 0, 0, 0);
        chk(r_cause == 2'd1, "R4 reset first", 32'(r_cause), 1);
        rst_pend_n = 1; fiq_mask = 1; irq_mask = 1; busy_left = 1;
        run(0, 1, 0, 0, 0);
        chk(r_status == 2'd0 && lat == 4, "R4 masked ignored", 32'(r_status), 0);
        chk(r_cause == 2'd0, "R4 no cause", 32'(r_cause), 0);
        fiq_n = 1; irq_n = 1; fiq_mask = 0; irq_mask = 0;
    endtask

    task automatic t_load();
        busy_left = 0; inc_left = 2; abort_en = 0;
        run(3, 1, 32'h100, 1, 0);
        chk(lat == 6, "R6 load latency", 32'(lat), 6);
        chk(n_xfer == 1 && n_data == 3, "R6 data phases", 32'(n_data), 3);
        for (int i = 0; i < 3; i++)
            chk(dlog[i] == 32'hA5A5_0100 + 32'(4 * i), "R6 load word", dlog[i], 32'hA5A5_0100 + 32'(4 * i));
        chk(r_status == 2'd0 && r_wb == 1, "R9 load wb", 32'(r_wb), 1);
        inc_left = 0;
        run(3, 1, 32'h180, 0, 0);
        chk(r_wb == 0, "R9 no wb request", 32'(r_wb), 0);
    endtask

    task automatic t_store();
        busy_left = 0; inc_left = 1; abort_en = 0;
        run(4, 1, 32'h200, 1, 0);
        chk(lat == 4 && n_memwr == 2, "R7 store writes", 32'(n_memwr), 2);
        chk(wa[0] == 32'h200 && wd[0] == 32'hC500_0000, "R7 word0", wd[0], 32'hC500_0000);
        chk(wa[1] == 32'h204 && wd[1] == 32'hC500_0001, "R7 word1", wd[1], 32'hC500_0001);
        chk(r_wb == 1, "R9 store wb", 32'(r_wb), 1);
    endtask

    task automatic t_abort();
        busy_left = 0; inc_left = 3; abort_en = 1; abort_addr = 32'h304;
        run(3, 1, 32'h300, 1, 0);
        chk(r_status == 2'd2 && lat == 5, "R8 load abort", 32'(r_status), 2);
        chk(n_memrd == 2 && n_data == 1, "R8 abort beats inc", 32'(n_data), 1);
        chk(r_wb == 0, "R9 abort early no wb", 32'(r_wb), 0);
        inc_left = 3;
        run(3, 1, 32'h300, 1, 1);
        chk(r_wb == 1, "R9 late abort wb", 32'(r_wb), 1);
        inc_left = 3; abort_addr = 32'h404;
        run(4, 1, 32'h400, 0, 0);
        chk(r_status == 2'd2 && n_memwr == 2 && n_data == 2, "R8 store abort", 32'(n_memwr), 2);
        abort_en = 0; inc_left = 0;
    endtask

    task automatic t_regs();
        busy_left = 0; rdbase = 32'h1234_0000;
        run(2, 1, 0, 0, 0);
        chk(lat == 4 && n_ccyc == 1 && n_icyc == 1, "R10 read cycles", 32'(lat), 4);
        chk(r_rd == 32'h1234_0000, "R10 read data", r_rd, 32'h1234_0000);
        src_data = 32'hDEAD_BEEF;
        run(1, 1, 0, 0, 0);
        chk(lat == 3 && n_ccyc == 1 && n_icyc == 0, "R10 write cycles", 32'(lat), 3);
        chk(first_wdata == 32'hDEAD_BEEF, "R10 write data", first_wdata, 32'hDEAD_BEEF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_denied();
        t_busy();
        t_cant();
        t_intr();
        t_prio();
        t_load();
        t_store();
        t_abort();
        t_regs();
        summary_and_end();
    end
endmodule